// File: doc/BRIEF.md
# Page-Mode Parallel ROM Read Controller

This block sits between a synchronous request port and an external parallel mask ROM that supports fast reads within a page. A client asks for a burst of one or more consecutive items with a start address, a count and a flag for byte or 16-bit word reads. The controller drives the ROM's chip enable, output enable, width select and address pins. It captures the data bus after a fixed number of clock cycles and returns each item with a valid strobe. It flags the final item of the burst.

All analog timing is reduced to cycle counts. Each limit in nanoseconds is divided by the clock period and rounded up. With the default 8 ns clock the counts are:
- 25 cycles of power-up hold;
- 13 cycles for a random access;
- 4 cycles for an access inside the open page;
- 4 cycles of bus release after a burst.

While chip enable stays low across a burst, an item whose upper word-address bits match the previous item is read with the short delay. Any other item is read with the long delay. In byte mode the least significant address bit leaves on a dedicated pin. That pin replaces the ROM's top data pin, and only the low data byte is used.

Top module: `prom_page_reader`

## Requirements
- R1: After reset is released, `rom_ce_n` stays high and `req_ready` stays low for the power-up hold. That is 25 samples at the defaults, and the block is idle from the 26th.
- R2: `req_ready` is high only when the block is idle, and `rom_ce_n` is high whenever it is idle. An idle phase therefore closes the page.
- R3: The first item of every request is a random access. The address pins hold the item's word address for 13 cycles. The datum appears on `rsp_data` with `rsp_valid` high in the cycle after that.
- R4: A later item of a burst whose word address, shifted right by the page width (2 bits at the defaults), equals that of the previous item is a page hit. Its address is held for 4 cycles before capture.
- R5: A later item of a burst whose shifted word address differs from the previous item's is read with the full 13-cycle random delay.
- R6: In byte mode (`req_byte`=1) the item address is a byte address. `rom_addr` carries bits [21:1] of it, `rom_lsb` carries bit 0, and `rom_lsb_oe` is 1. `rom_word_sel` is 0. `rsp_data` is {8'h00, `rom_dq`[7:0]}, so pins `rom_dq`[15:8] have no effect.
- R7: In word mode (`req_byte`=0) `rom_addr` is the request address, `rom_word_sel` is 1, `rom_lsb_oe` is 0, and `rsp_data` is the full 16-bit `rom_dq`.
- R8: A request with `req_len`=N returns N+1 items at consecutive addresses. The address wraps at the top of the address space. `rsp_last` is high together with `rsp_valid` on the final item only.
- R9: After the final capture, chip enable is high and `req_ready` is low for 4 bus-release cycles before the next request can be accepted.
- R10: `rom_oe_n` equals `rom_ce_n` in every cycle.
- R11: `rom_word_sel` never changes while chip enable stays low. A change of width therefore always meets a full random access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted in this cycle when valid |
| req_addr | input | ADDR_W+1 | Start address (word address in low ADDR_W bits, or byte address) |
| req_len | input | LEN_W | Item count minus one |
| req_byte | input | 1 | 1 = byte reads, 0 = 16-bit word reads |
| rsp_valid | output | 1 | One-cycle strobe with each datum |
| rsp_data | output | DATA_W | Read datum |
| rsp_last | output | 1 | Marks the final datum of a burst |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_word_sel | output | 1 | ROM width select, 1 = word |
| rom_addr | output | ADDR_W | ROM word address pins |
| rom_lsb | output | 1 | Byte-select address bit for the shared top data pin |
| rom_lsb_oe | output | 1 | Drive enable for the shared top data pin |
| rom_dq | input | DATA_W | ROM data bus |

## Verification
The assertions check the following on every cycle:
- the power-up hold;
- that ready and output enable agree with chip enable;
- address stability between captures;
- the cleared upper byte in byte mode;
- last-with-valid;
- the width select held while the page is open;
- a lower bound on the spacing of data strobes.

Only the bench's cycle-by-cycle reference shows certain behaviours:
- the exact delay chosen for each item (page hit against page crossing, in both widths and across address wrap);
- burst length and address sequence;
- correct data values;
- the release gap between back-to-back requests.

// File: rtl/prom_pkg.sv
package prom_pkg;

  typedef enum logic [1:0] {
    ST_PWR  = 2'd0,
    ST_IDLE = 2'd1,
    ST_ACC  = 2'd2,
    ST_REL  = 2'd3
  } prom_state_e;

  // Nanosecond limit to clock cycles, rounded up, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/prom_timer.sv
module prom_timer #(
  parameter int W       = 5,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/prom_page_track.sv
module prom_page_track #(
  parameter int TAG_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             close,
  input  logic [TAG_W-1:0] probe_tag,
  output logic             hit
);
  logic [TAG_W-1:0] tag_q;
  logic             open_q;
  logic             open_d;

  always_comb begin
    open_d = open_q;
    if (close)    open_d = 1'b0;
    else if (set) open_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tag_q <= '0;
    else if (set) tag_q <= set_tag;
  end

  assign hit = open_q && (probe_tag == tag_q);
endmodule

// File: rtl/prom_lane_fmt.sv
module prom_lane_fmt #(
  parameter int DATA_W = 16
) (
  input  logic              byte_mode,
  input  logic [DATA_W-1:0] dq,
  output logic [DATA_W-1:0] data
);
  localparam int LANE_W = DATA_W / 2;

  always_comb begin
    if (byte_mode) data = {{(DATA_W-LANE_W){1'b0}}, dq[LANE_W-1:0]};
    else           data = dq;
  end
endmodule

// File: rtl/prom_page_reader.sv
module prom_page_reader #(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int LEN_W    = 4,
  parameter int PAGE_W   = 2,
  parameter int CLK_PS   = 8000,
  parameter int PWR_NS   = 200,
  parameter int ACC_NS   = 100,
  parameter int PAGE_NS  = 25,
  parameter int REL_NS   = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W:0]   req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_byte,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic              rom_word_sel,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_lsb,
  output logic              rom_lsb_oe,
  input  logic [DATA_W-1:0] rom_dq
);
  import prom_pkg::*;

  localparam int PWR_CYC  = ns_to_cyc(PWR_NS, CLK_PS);
  localparam int ACC_CYC  = ns_to_cyc(ACC_NS, CLK_PS);
  localparam int PAGE_CYC = ns_to_cyc(PAGE_NS, CLK_PS);
  localparam int REL_CYC  = ns_to_cyc(REL_NS, CLK_PS);
  localparam int MAX_A    = (PWR_CYC > ACC_CYC) ? PWR_CYC : ACC_CYC;
  localparam int MAX_B    = (PAGE_CYC > REL_CYC) ? PAGE_CYC : REL_CYC;
  localparam int MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam int TAG_W    = ADDR_W - PAGE_W;

  prom_state_e       state_q, state_d;
  logic [ADDR_W:0]   unit_q, unit_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              byte_q, byte_d;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  logic              trk_set, trk_close, trk_hit;
  logic [TAG_W-1:0]  trk_tag;
  logic [ADDR_W:0]   unit_nx;
  logic [ADDR_W-1:0] word_cur, word_nx, word_req;
  logic              capture;
  logic [DATA_W-1:0] fmt_data;
  logic              rsp_valid_q, rsp_last_q;
  logic [DATA_W-1:0] rsp_data_q;

  function automatic logic [ADDR_W-1:0] word_of(input logic [ADDR_W:0] u, input logic b);
    return b ? u[ADDR_W:1] : u[ADDR_W-1:0];
  endfunction

  assign unit_nx  = unit_q + 1'b1;
  assign word_cur = word_of(unit_q, byte_q);
  assign word_nx  = word_of(unit_nx, byte_q);
  assign word_req = word_of(req_addr, req_byte);
  assign capture  = (state_q == ST_ACC) && tmr_done;

  prom_timer #(.W(CNT_W), .RST_VAL(PWR_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  prom_page_track #(.TAG_W(TAG_W)) u_track (
    .clk(clk), .rst_n(rst_n), .set(trk_set), .set_tag(trk_tag), .close(trk_close),
    .probe_tag(word_nx[ADDR_W-1:PAGE_W]), .hit(trk_hit)
  );

  prom_lane_fmt #(.DATA_W(DATA_W)) u_fmt (
    .byte_mode(byte_q), .dq(rom_dq), .data(fmt_data)
  );

  always_comb begin
    state_d   = state_q;
    unit_d    = unit_q;
    left_d    = left_q;
    byte_d    = byte_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    trk_set   = 1'b0;
    trk_close = 1'b0;
    trk_tag   = word_cur[ADDR_W-1:PAGE_W];
    case (state_q)
      ST_PWR: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (req_valid) begin
          unit_d   = req_addr;
          left_d   = req_len;
          byte_d   = req_byte;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(ACC_CYC - 1);
          trk_set  = 1'b1;
          trk_tag  = word_req[ADDR_W-1:PAGE_W];
          state_d  = ST_ACC;
        end
      end
      ST_ACC: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          if (left_q == '0) begin
            tmr_val   = CNT_W'(REL_CYC - 1);
            trk_close = 1'b1;
            state_d   = ST_REL;
          end else begin
            unit_d  = unit_nx;
            left_d  = left_q - 1'b1;
            tmr_val = trk_hit ? CNT_W'(PAGE_CYC - 1) : CNT_W'(ACC_CYC - 1);
            trk_set = 1'b1;
            trk_tag = word_nx[ADDR_W-1:PAGE_W];
          end
        end
      end
      default: begin
        if (tmr_done) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWR;
      unit_q  <= '0;
      left_q  <= '0;
      byte_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      unit_q  <= unit_d;
      left_q  <= left_d;
      byte_q  <= byte_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_last_q  <= 1'b0;
    end else begin
      rsp_valid_q <= capture;
      rsp_last_q  <= capture && (left_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rsp_data_q <= '0;
    else if (capture) rsp_data_q <= fmt_data;
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign rom_ce_n     = (state_q != ST_ACC);
  assign rom_oe_n     = (state_q != ST_ACC);
  assign rom_word_sel = ~byte_q;
  assign rom_addr     = word_cur;
  assign rom_lsb      = unit_q[0];
  assign rom_lsb_oe   = byte_q && (state_q == ST_ACC);
  assign rsp_valid    = rsp_valid_q;
  assign rsp_data     = rsp_data_q;
  assign rsp_last     = rsp_last_q;
endmodule

// File: rtl/prom_page_reader_chk.sv
module prom_page_reader_chk #(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int PWR_CYC  = 25,
  parameter int PAGE_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_last,
  input logic              rom_ce_n,
  input logic              rom_oe_n,
  input logic              rom_word_sel,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              rom_lsb,
  input logic              rom_lsb_oe
);
  localparam int PW_W = $clog2(PWR_CYC + 1) + 1;
  localparam int GP_W = $clog2(PAGE_CYC + 1) + 1;
  localparam int LANE = DATA_W / 2;

  logic [PW_W-1:0] pwr_cnt;
  logic [GP_W-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pwr_cnt <= '0;
    else if (pwr_cnt < PW_W'(PWR_CYC)) pwr_cnt <= pwr_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      gap_cnt <= '1;
    else if (rsp_valid)              gap_cnt <= '0;
    else if (gap_cnt != '1)          gap_cnt <= gap_cnt + 1'b1;
  end

  a_r1_pwrup_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_cnt < PW_W'(PWR_CYC)) |-> (rom_ce_n && !req_ready));

  a_r2_ready_page_closed: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> rom_ce_n);

  a_r10_oe_tracks_ce: assert property (@(posedge clk) disable iff (!rst_n)
    rom_oe_n == rom_ce_n);

  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && $past(!rom_ce_n) && !rsp_valid) |-> $stable({rom_addr, rom_lsb}));

  a_r6_upper_byte_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rom_word_sel) |-> (rsp_data[DATA_W-1:LANE] == '0));

  a_r6_lsb_pin_byte_only: assert property (@(posedge clk) disable iff (!rst_n)
    rom_lsb_oe |-> (!rom_word_sel && !rom_ce_n));

  a_r8_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid);

  a_r11_width_held_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && $past(!rom_ce_n)) |-> $stable(rom_word_sel));

  a_r4_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (gap_cnt >= GP_W'(PAGE_CYC - 1)));
endmodule

bind prom_page_reader prom_page_reader_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PWR_CYC(PWR_CYC), .PAGE_CYC(PAGE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .rsp_last(rsp_last), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
  .rom_word_sel(rom_word_sel), .rom_addr(rom_addr), .rom_lsb(rom_lsb),
  .rom_lsb_oe(rom_lsb_oe)
);

// File: tb/prom_page_reader_bench.sv
module prom_page_reader_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 21;
  localparam int T_PWR = 25, T_RAND = 13, T_PAGE = 4, T_REL = 4;

  typedef struct {
    bit          ce_n;
    bit          ready;
    bit          act;
    bit [AW-1:0] addr;
    bit          byt;
    bit          lsb;
    bit          rv;
    bit [15:0]   rd;
    bit          rl;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [AW:0] req_addr = '0;
  logic [3:0]  req_len = '0;
  logic        req_byte = 1'b0;
  logic        rsp_valid, rsp_last;
  logic [15:0] rsp_data;
  logic        rom_ce_n, rom_oe_n, rom_word_sel, rom_lsb, rom_lsb_oe;
  logic [AW-1:0] rom_addr;
  logic [15:0] rom_dq;

  int checks = 0, errors = 0, pwr_left = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  prom_page_reader u_prom_page_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_byte(req_byte),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_word_sel(rom_word_sel),
    .rom_addr(rom_addr), .rom_lsb(rom_lsb), .rom_lsb_oe(rom_lsb_oe), .rom_dq(rom_dq)
  );

  function automatic logic [15:0] rom_val(input int w);
    logic [31:0] x;
    x = w * 32'h3B1D;
    return x[15:0] ^ 16'(w >> 3) ^ 16'h5A5A;
  endfunction

  // ROM model: upper pins carry junk in byte mode, bus idles at a fixed pattern.
  always_comb begin
    logic [15:0] v;
    v = rom_val(int'(rom_addr));
    if (rom_ce_n || rom_oe_n) rom_dq = 16'hF00F;
    else if (rom_word_sel)    rom_dq = v;
    else                      rom_dq = {rom_lsb, 7'h6B, (rom_lsb ? v[15:8] : v[7:0])};
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic build_trace(input logic [AW:0] a, input int len, input bit byt);
    bit [15:0] prev = '0;
    int        ptag = 0;
    for (int i = 0; i <= len; i++) begin
      int    u, w, tg, d;
      string t;
      bit [15:0] v, dat;
      exp_t  e;
      u  = (int'(a) + i) & ((1 << (AW + 1)) - 1);
      w  = byt ? (u >> 1) : (u & ((1 << AW) - 1));
      tg = w >> 2;
      if (i == 0)        begin d = T_RAND; t = byt ? "R3/R6" : "R3/R7"; end
      else if (tg == ptag) begin d = T_PAGE; t = "R4"; end
      else               begin d = T_RAND; t = "R5"; end
      for (int k = 0; k < d; k++) begin
        e.ce_n = 1'b0; e.ready = 1'b0; e.act = 1'b1; e.addr = AW'(w);
        e.byt = byt; e.lsb = u[0]; e.rv = (k == 0 && i > 0); e.rd = prev;
        e.rl = 1'b0; e.tag = (k == 0 && i > 0) ? "R8" : t;
        q.push_back(e);
      end
      v    = rom_val(w);
      dat  = byt ? {8'h00, (u[0] ? v[15:8] : v[7:0])} : v;
      prev = dat;
      ptag = tg;
    end
    for (int k = 0; k < T_REL; k++) begin
      exp_t e;
      e.ce_n = 1'b1; e.ready = 1'b0; e.act = 1'b0; e.addr = '0; e.byt = byt;
      e.lsb = 1'b0; e.rv = (k == 0); e.rd = prev; e.rl = (k == 0);
      e.tag = (k == 0) ? "R8" : "R9";
      q.push_back(e);
    end
  endtask

  // Reference comparison on every falling edge.
  always @(negedge clk) begin
    chk("R10", rom_oe_n, rom_ce_n);
    if (!rst_n) begin
      pwr_left = T_PWR;
      chk("R1", {rom_ce_n, req_ready, rsp_valid}, 3'b100);
    end else if (pwr_left > 0) begin
      chk("R1", {rom_ce_n, req_ready}, 2'b10);
      pwr_left--;
    end else if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, {rom_ce_n, req_ready}, {e.ce_n, e.ready});
      if (e.act) begin
        chk(e.tag, rom_addr, e.addr);
        chk(e.byt ? "R6" : "R7", {rom_word_sel, rom_lsb_oe}, {~e.byt, e.byt});
        if (e.byt) chk("R6", rom_lsb, e.lsb);
      end
      chk(e.tag, rsp_valid, e.rv);
      if (e.rv) begin
        chk(e.byt ? "R6" : "R7", rsp_data, e.rd);
        chk("R8", rsp_last, e.rl);
      end
    end else begin
      chk("R2", {rom_ce_n, req_ready, rsp_valid}, 3'b110);
    end
    if (rst_n && pwr_left == 0 && q.size() == 0 && req_valid && req_ready)
      build_trace(req_addr, int'(req_len), req_byte);
  end

  task automatic issue(input logic [AW:0] a, input int len, input bit byt);
    @(posedge clk); #2;
    req_valid = 1'b1; req_addr = a; req_len = 4'(len); req_byte = byt;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
  endtask

  task automatic drop();
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0 || !req_ready);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (T_PWR + 5) @(posedge clk);
    // R3 R4 R5 R7: word burst crossing one page boundary
    issue(22'h000001, 5, 1'b0); drop(); wait_idle();
    // R6: byte burst, hit inside a word, then crossing
    issue(22'h00000E, 3, 1'b0 | 1'b1); drop(); wait_idle();
    // R7 R8: single item at the top word address
    issue(22'h1FFFFF, 0, 1'b0); drop(); wait_idle();
    // R9 R11: back-to-back requests with a width change, valid held
    issue(22'h000040, 1, 1'b0);
    issue(22'h000081, 2, 1'b1); drop(); wait_idle();
    // R5 R8: byte burst wrapping past the top of the address space
    issue(22'h3FFFFE, 3, 1'b1); drop(); wait_idle();
    // R4: long word burst inside and across pages
    issue(22'h000100, 9, 1'b0); drop(); wait_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule